// File: doc/BRIEF.md
# Interrupt-Driven Erase Suspend Controller

This block runs next to a flash command engine for the whole of a sector erase. While the erase is underway it watches a pending-interrupt flag. When an interrupt is waiting, the device supports erase suspension and no other suspended operation is open, it issues the suspend command to the address under erase. It then polls the device status until the device confirms that it has stopped. If the erase is still unfinished at that point, the block switches the device to read-array mode. After a short settle time it tells the host that the flash can be read again, so that interrupt code can run from it.

When the host gives the flash back, the block sends the resume command and returns to watching. If the status shows that the erase completed before the suspend took hold, the block reports an early finish and does not enter the suspended state. If the device never confirms, the attempt is dropped after a poll limit. The block also keeps the erase time budget: it loads the budget when an erase starts and counts it down only while the erase is actually running. The count is frozen from the suspend command until the resume command. The engine's done flag passes through unchanged.

Top module: `erase_irq_suspend`

## Requirements
- R1: While monitoring, if `erase_active`, `irq_pending` and `suspend_ok` are all high and `other_suspended` is low at a clock edge, then in the next cycle `wr_en` is high, `wr_data` is 0x00B0 and `wr_addr` equals the `erase_addr` sampled at that edge.
- R2: If any one of those four conditions fails, no suspend command is written and `suspended` stays low.
- R3: During polling, a status word with bit 7 set and bit 6 set causes, in the next cycle, a write of 0x00F0 to the same address, with `suspended` and `suspend_seen` both high.
- R4: During polling, a status word with bit 7 set and bit 6 clear causes a one-cycle `finished_early` pulse in the next cycle. There is no write, `suspended` stays low, and monitoring resumes.
- R5: If bit 7 is never seen, a one-cycle `suspend_abort` pulse appears POLL_LIMIT cycles after the cycle of the suspend write. There is no write and `suspended` stays low.
- R6: `readable` rises SETTLE cycles (8 by default) after the cycle of the read-array write and is high only while `suspended` is high.
- R7: While `readable` is high, `host_release` causes, in the next cycle, a write of 0x0030 to the same address, with `suspended` and `readable` both low.
- R8: `budget_left` loads `budget_init` one cycle after `erase_start`. It then drops by one for each cycle in which the erase runs unsuspended, saturating at zero. It does not change while `erase_active` is low, or from the suspend write up to and including the resume write.
- R9: `done_out` equals `engine_done` in every cycle.
- R10: `suspend_seen` stays high after a resume and is cleared one cycle after `erase_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_start | input | 1 | New erase begins; loads the budget and clears `suspend_seen` |
| budget_init | input | BW | Wait budget for the new erase, in cycles |
| erase_active | input | 1 | The engine is erasing |
| erase_addr | input | AW | Address of the sector under erase |
| irq_pending | input | 1 | An interrupt is waiting |
| suspend_ok | input | 1 | The device supports erase suspension |
| other_suspended | input | 1 | Another suspended operation is outstanding |
| host_release | input | 1 | The host has finished with the readable flash |
| flash_rdata | input | DW | Status read from the device |
| engine_done | input | 1 | Done flag of the engine |
| wr_en | output | 1 | Flash write cycle strobe |
| wr_addr | output | AW | Flash write address |
| wr_data | output | DW | Flash write command |
| readable | output | 1 | Flash is in read-array mode and may be fetched from |
| suspended | output | 1 | The erase is held suspended |
| suspend_seen | output | 1 | A suspend took place during this erase |
| finished_early | output | 1 | The erase completed before the suspend took hold |
| suspend_abort | output | 1 | The device did not confirm the suspend in time |
| budget_left | output | BW | Remaining erase wait budget |
| done_out | output | 1 | `engine_done` passed through |

## Verification
The bench sweeps all sixteen combinations of the four trigger inputs. A gate that dropped one condition would write a suspend command where none belongs. Status delays from zero to three cycles are tried, with the read-array write and the readable rise checked cycle by cycle: an off-by-one settle counter shows as `readable` rising a cycle early or late. The budget is compared across the suspended window and on the first cycle after the resume. A design that kept counting through the suspension, or that failed to restart the count, gives a different value. The early-finish and poll-timeout paths are each checked to give exactly one pulse and no read-array write.

// File: rtl/esi_pkg.sv
package esi_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_POLL   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_READ   = 2'd3
  } esi_state_e;

  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hF0;
  localparam logic [7:0] CMD_RESUME     = 8'h30;

  localparam int unsigned STAT_READY_POS = 7;
  localparam int unsigned STAT_BUSY_POS  = 6;

endpackage

// File: rtl/esi_timer.sv
module esi_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = clr | en;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_ce)  cnt_q <= cnt_d;
  end

  assign hit = en & (cnt_q == LAST);
endmodule

// File: rtl/esi_budget.sv
module esi_budget #(
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  input  logic          run,
  output logic [BW-1:0] left
);
  logic [BW-1:0] left_q, left_d;
  logic          left_ce;

  always_comb begin
    left_ce = load | (run & (left_q != '0));
    left_d  = load ? load_val : left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        left_q <= '0;
    else if (left_ce)  left_q <= left_d;
  end

  assign left = left_q;
endmodule

// File: rtl/esi_fsm.sv
module esi_fsm
  import esi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       erase_active,
  input  logic       irq_pending,
  input  logic       suspend_ok,
  input  logic       other_suspended,
  input  logic       host_release,
  input  logic       stat_ready,
  input  logic       stat_busy,
  input  logic       poll_hit,
  input  logic       settle_hit,
  input  logic       clear_seen,
  output esi_state_e state,
  output logic       cmd_valid,
  output logic [7:0] cmd_code,
  output logic       addr_capture,
  output logic       fin_pulse,
  output logic       abort_pulse,
  output logic       seen
);
  esi_state_e state_q, state_d;
  logic       cmd_valid_d;
  logic [7:0] cmd_q, cmd_d;
  logic       fin_q, fin_d, abort_q, abort_d;
  logic       seen_q, seen_d;
  logic       trigger;

  assign trigger = erase_active & irq_pending & suspend_ok & ~other_suspended;

  always_comb begin
    state_d      = state_q;
    cmd_valid_d  = 1'b0;
    cmd_d        = cmd_q;
    fin_d        = 1'b0;
    abort_d      = 1'b0;
    seen_d       = clear_seen ? 1'b0 : seen_q;
    addr_capture = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (trigger) begin
          state_d      = ST_POLL;
          cmd_valid_d  = 1'b1;
          cmd_d        = CMD_SUSPEND;
          addr_capture = 1'b1;
        end
      end
      ST_POLL: begin
        if (stat_ready) begin
          if (!stat_busy) begin
            state_d = ST_RUN;
            fin_d   = 1'b1;
          end else begin
            state_d     = ST_SETTLE;
            cmd_valid_d = 1'b1;
            cmd_d       = CMD_READ_ARRAY;
            seen_d      = 1'b1;
          end
        end else if (poll_hit) begin
          state_d = ST_RUN;
          abort_d = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_hit) state_d = ST_READ;
      end
      ST_READ: begin
        if (host_release) begin
          state_d     = ST_RUN;
          cmd_valid_d = 1'b1;
          cmd_d       = CMD_RESUME;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      cmd_valid <= 1'b0;
      fin_q     <= 1'b0;
      abort_q   <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_valid <= cmd_valid_d;
      fin_q     <= fin_d;
      abort_q   <= abort_d;
      seen_q    <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cmd_q <= '0;
    else if (cmd_valid_d)  cmd_q <= cmd_d;
  end

  assign state       = state_q;
  assign cmd_code    = cmd_q;
  assign fin_pulse   = fin_q;
  assign abort_pulse = abort_q;
  assign seen        = seen_q;
endmodule

// File: rtl/erase_irq_suspend.sv
module erase_irq_suspend
  import esi_pkg::*;
#(
  parameter int unsigned AW         = 24,
  parameter int unsigned DW         = 16,
  parameter int unsigned BW         = 16,
  parameter int unsigned POLL_LIMIT = 12_500_000,
  parameter int unsigned SETTLE     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_start,
  input  logic [BW-1:0] budget_init,
  input  logic          erase_active,
  input  logic [AW-1:0] erase_addr,
  input  logic          irq_pending,
  input  logic          suspend_ok,
  input  logic          other_suspended,
  input  logic          host_release,
  input  logic [DW-1:0] flash_rdata,
  input  logic          engine_done,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          readable,
  output logic          suspended,
  output logic          suspend_seen,
  output logic          finished_early,
  output logic          suspend_abort,
  output logic [BW-1:0] budget_left,
  output logic          done_out
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  esi_state_e    state;
  logic          poll_hit, settle_hit;
  logic          addr_capture;
  logic [7:0]    cmd_code;
  logic [AW-1:0] addr_q;
  logic          unused_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign unused_rdata = ^(flash_rdata & ~DW'(8'hC0));

  esi_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .erase_active    (erase_active),
    .irq_pending     (irq_pending),
    .suspend_ok      (suspend_ok),
    .other_suspended (other_suspended),
    .host_release    (host_release),
    .stat_ready      (flash_rdata[STAT_READY_POS]),
    .stat_busy       (flash_rdata[STAT_BUSY_POS]),
    .poll_hit        (poll_hit),
    .settle_hit      (settle_hit),
    .clear_seen      (erase_start),
    .state           (state),
    .cmd_valid       (wr_en),
    .cmd_code        (cmd_code),
    .addr_capture    (addr_capture),
    .fin_pulse       (finished_early),
    .abort_pulse     (suspend_abort),
    .seen            (suspend_seen)
  );

  esi_timer #(.LIMIT(POLL_LIMIT)) u_poll_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (state != ST_POLL),
    .en    (state == ST_POLL),
    .hit   (poll_hit)
  );

  esi_timer #(.LIMIT(SETTLE)) u_settle_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (state != ST_SETTLE),
    .en    (state == ST_SETTLE),
    .hit   (settle_hit)
  );

  esi_budget #(.BW(BW)) u_budget (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (erase_start),
    .load_val (budget_init),
    .run      (erase_active & (state == ST_RUN)),
    .left     (budget_left)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)         addr_q <= '0;
    else if (addr_capture)  addr_q <= erase_addr;
  end

  assign wr_addr   = addr_q;
  assign wr_data   = DW'(cmd_code);
  assign readable  = (state == ST_READ);
  assign suspended = (state == ST_SETTLE) | (state == ST_READ);
  assign done_out  = engine_done;
endmodule

// File: rtl/esi_checker.sv
module esi_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          erase_start,
  input logic          erase_active,
  input logic          irq_pending,
  input logic          suspend_ok,
  input logic          other_suspended,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          readable,
  input logic          suspended,
  input logic          suspend_seen,
  input logic          finished_early,
  input logic          suspend_abort,
  input logic [BW-1:0] budget_left
);
  AST_SUSPEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == DW'(8'hB0)) |-> $past(erase_active && irq_pending && suspend_ok && !other_suspended)); // R1

  AST_ENTRY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> (wr_en && wr_data == DW'(8'hF0) && suspend_seen)); // R3

  AST_EARLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    finished_early |-> (!suspended && !wr_en)); // R4

  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_abort |-> (!suspended && !wr_en)); // R5

  AST_READABLE_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    readable |-> suspended); // R6

  AST_RESUME_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspended) |-> (wr_en && wr_data == DW'(8'h30))); // R7

  AST_BUDGET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !erase_start) |=> $stable(budget_left)); // R8
endmodule

bind erase_irq_suspend esi_checker #(.DW(DW), .BW(BW)) u_esi_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .erase_start     (erase_start),
  .erase_active    (erase_active),
  .irq_pending     (irq_pending),
  .suspend_ok      (suspend_ok),
  .other_suspended (other_suspended),
  .wr_en           (wr_en),
  .wr_data         (wr_data),
  .readable        (readable),
  .suspended       (suspended),
  .suspend_seen    (suspend_seen),
  .finished_early  (finished_early),
  .suspend_abort   (suspend_abort),
  .budget_left     (budget_left)
);

// File: tb/test_erase_irq_suspend.sv
`timescale 1ns/1ps
module test_erase_irq_suspend;
  localparam int AW = 24, DW = 16, BW = 16, PL = 16, ST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase_start = 0, erase_active = 0, irq_pending = 0, suspend_ok = 0;
  logic other_suspended = 0, host_release = 0, engine_done = 0;
  logic [BW-1:0] budget_init = '0;
  logic [AW-1:0] erase_addr = '0;
  logic [DW-1:0] flash_rdata = '0;
  logic wr_en, readable, suspended, suspend_seen, finished_early, suspend_abort, done_out;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [BW-1:0] budget_left;

  int total = 0, failed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  erase_irq_suspend #(.AW(AW), .DW(DW), .BW(BW), .POLL_LIMIT(PL), .SETTLE(ST)) i_erase_irq_suspend (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failed++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [BW-1:0] b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("reset wr_en", wr_en, 0);
    chk("reset suspended", suspended, 0);
    chk("reset readable", readable, 0);
    chk("R10 reset seen", suspend_seen, 0);
    chk("R8 reset budget", budget_left, 0);

    // R8: load then count while erasing
    erase_start = 1; budget_init = 1000; erase_active = 1;
    step();
    chk("R8 load", budget_left, 1000);
    erase_start = 0;
    repeat (5) step();
    chk("R8 count", budget_left, 995);
    erase_active = 0;
    repeat (3) step();
    chk("R8 idle hold", budget_left, 995);

    // R9
    engine_done = 1; #1 chk("R9 done high", done_out, 1);
    engine_done = 0; #1 chk("R9 done low", done_out, 0);

    // R1 / R2 sweep over trigger inputs
    for (int m = 0; m < 16; m++) begin
      erase_active = m[3]; irq_pending = m[2]; suspend_ok = m[1]; other_suspended = ~m[0];
      erase_addr = AW'(24'h200 + m);
      step();
      if (m == 15) begin
        chk("R1 suspend wr", wr_en, 1);
        chk("R1 suspend code", wr_data, 16'h00B0);
        chk("R1 suspend addr", wr_addr, 24'h200 + m);
        irq_pending = 0; flash_rdata = 16'h0080;
        step();
        chk("R4 early pulse", finished_early, 1);
        chk("R4 no write", wr_en, 0);
        chk("R4 not suspended", suspended, 0);
        flash_rdata = 0;
        step();
        chk("R4 pulse single", finished_early, 0);
      end else begin
        chk("R2 no write", wr_en, 0);
        step();
        chk("R2 no write 2", wr_en, 0);
        chk("R2 not suspended", suspended, 0);
      end
      erase_active = 0; irq_pending = 0; suspend_ok = 0; other_suspended = 0;
      step();
    end

    // R3/R6/R7/R8/R10 with various status delays
    for (int d = 0; d < 4; d++) begin
      erase_start = 1; budget_init = BW'(2000 + d); erase_active = 1;
      step();
      erase_start = 0;
      chk("R10 cleared", suspend_seen, 0);
      step();
      suspend_ok = 1; irq_pending = 1; erase_addr = AW'(24'h1000 + d);
      step();
      chk("R1 code", wr_data, 16'h00B0);
      chk("R1 wr", wr_en, 1);
      b0 = budget_left;
      chk("R8 charged before suspend", b0, 2000 + d - 2);
      irq_pending = 0;
      for (int k = 0; k < d; k++) begin
        step();
        chk("R3 waiting", suspended, 0);
      end
      flash_rdata = 16'h00C0;
      step();
      flash_rdata = 0;
      chk("R3 rd-array wr", wr_en, 1);
      chk("R3 rd-array code", wr_data, 16'h00F0);
      chk("R3 addr", wr_addr, 24'h1000 + d);
      chk("R3 suspended", suspended, 1);
      chk("R3 seen", suspend_seen, 1);
      for (int k = 1; k < ST; k++) begin
        step();
        chk("R6 not yet readable", readable, 0);
      end
      step();
      chk("R6 readable", readable, 1);
      repeat (d) step();
      chk("R8 frozen", budget_left, b0);
      host_release = 1;
      step();
      host_release = 0;
      chk("R7 resume wr", wr_en, 1);
      chk("R7 resume code", wr_data, 16'h0030);
      chk("R7 resume addr", wr_addr, 24'h1000 + d);
      chk("R7 suspended low", suspended, 0);
      chk("R7 readable low", readable, 0);
      chk("R8 frozen at resume", budget_left, b0);
      step();
      chk("R8 restart", budget_left, b0 - 1);
      chk("R10 sticky", suspend_seen, 1);
      suspend_ok = 0; erase_active = 0;
      step();
    end

    // R5: no confirmation
    erase_active = 1; suspend_ok = 1; irq_pending = 1;
    step();
    chk("R5 suspend wr", wr_data, 16'h00B0);
    irq_pending = 0; flash_rdata = 0;
    for (int k = 1; k < PL; k++) begin
      step();
      chk("R5 not yet", suspend_abort, 0);
    end
    step();
    chk("R5 abort pulse", suspend_abort, 1);
    chk("R5 no write", wr_en, 0);
    chk("R5 not suspended", suspended, 0);
    step();
    chk("R5 pulse single", suspend_abort, 0);

    finish_run();
  end
endmodule